// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-driven DMA engine. Host software keeps a ring of 32-byte descriptors in memory. Each descriptor carries a buffer address in word 0, a control word in word 1 and a status word in word 2. When a frame arrives on the input stream, the block reads the control word at the current ring pointer. A clear ownership bit means the descriptor is available to hardware. In that case the block reads the buffer address, writes the frame payload word by word into the buffer, and writes the status word. It then writes the control word with the ownership bit set, which hands the descriptor back to the host.

After each filled descriptor the pointer moves forward by 32 bytes. If the descriptor carried the end-of-ring flag, the pointer returns to the ring base instead. A descriptor that the host still owns causes the arriving frame to be consumed and discarded, and a saturating drop counter records it. Software controls the block through a base register, a loadable current pointer, a clear-state strobe, and poll-enable and suspend controls. The memory side is a simple request/acknowledge master. A read returns its data in the same cycle as its acknowledge.

Top module: `rx_ring_writer`

## Requirements
- R1: After synchronous reset, in_ready and mem_req are 0, drop_count is 0 and both the base and current pointers are 0.
- R2: While poll_en is 0 or suspend is 1 and no frame is in progress, the block accepts no input beat (in_ready stays 0) and issues no memory request. A frame already in progress runs to completion.
- R3: For each frame the block first reads the control word at pointer+4. If bit 31 of that word is 1 (host owns it), every beat of the frame is accepted and discarded. No memory write occurs, drop_count increments by one and saturates at its maximum, and the pointer does not move.
- R4: If bit 31 of the control word is 0, the block reads word 0 at the pointer as the buffer address. Payload beat k (32 bits) is written to buffer+4k, in order.
- R5: The byte length equals 4 bytes for each beat before the last plus in_nbytes (1 to 4) on the last beat.
- R6: The control word's bits [15:0] on entry give the buffer capacity. A beat whose byte offset is at or beyond the capacity is accepted but not written. When the frame exceeds the capacity, the reported length is the capacity and status bit 11 is set.
- R7: The status word is written to pointer+8 and holds in_port (sampled on the last beat) in bits [10:8]. Bit 11 is the truncation flag and all other bits are 0.
- R8: The last write of a filled descriptor goes to pointer+4. It has bit 31 = 1, bit 30 equal to the entry end-of-ring flag, bits 29 and 28 = 1, bits [27:16] = 0 and bits [15:0] = the length.
- R9: After a descriptor is filled, the pointer becomes the base address if the descriptor's end-of-ring flag (control bit 30) was set. Otherwise it becomes pointer+32.
- R10: A clr_state strobe loads the current pointer from the base register, and a ptr_we strobe loads it from ptr_in. clr_state takes priority over ptr_we, and ptr_we takes priority over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Allows descriptor fetching |
| suspend | input | 1 | Pauses fetching between frames |
| clr_state | input | 1 | Strobe: current pointer := base |
| base_we | input | 1 | Strobe: load ring base |
| base_in | input | ADDR_W | Ring base address |
| ptr_we | input | 1 | Strobe: load current pointer |
| ptr_in | input | ADDR_W | Current pointer value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Final beat of frame |
| in_nbytes | input | 3 | Valid bytes on final beat (1..4) |
| in_port | input | 3 | Source port, sampled on final beat |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| drop_count | output | DROP_W | Saturating count of discarded frames |

## Verification
The bench memory acknowledges each request in the cycle it is raised. With that memory, the control-word read happens in the cycle after a frame first appears with fetching allowed, and the address read happens one cycle later. The first payload beat can be accepted in the third cycle. The status write and the ownership write follow the last beat in consecutive cycles, and the pointer moves in the same cycle as the ownership write. Every memory write is compared, in the cycle it is issued, against an ordered list of expected writes that a behavioural model builds from the descriptor contents. drop_count and in_ready are sampled at the falling edge only after the model reports the frame complete, so the checks never depend on exact latency beyond that order.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 16;
    localparam int PORT_W     = 3;
    localparam int DESC_BYTES = 32;
    localparam int OFS_CTL    = 4;
    localparam int OFS_STAT   = 8;
    localparam int BIT_OWN    = 31;
    localparam int BIT_EOR    = 30;
    localparam int BIT_TRUNC  = 11;
    localparam int PORT_LSB   = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_CTL, S_ADR, S_DATA, S_STAT, S_FIN, S_DROP
    } rxw_state_e;

    typedef struct packed {
        logic             own;
        logic             eor;
        logic [LEN_W-1:0] cap;
    } rxw_desc_t;

    function automatic rxw_desc_t decode_ctl(input logic [WORD_W-1:0] w);
        rxw_desc_t d;
        d.own = w[BIT_OWN];
        d.eor = w[BIT_EOR];
        d.cap = w[LEN_W-1:0];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] build_ctl(input logic eor, input logic [LEN_W-1:0] len);
        return {1'b1, eor, 1'b1, 1'b1, 12'b0, len};
    endfunction

    function automatic logic [WORD_W-1:0] build_stat(input logic [PORT_W-1:0] port, input logic trunc);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PORT_LSB +: PORT_W] = port;
        w[BIT_TRUNC] = trunc;
        return w;
    endfunction
endpackage

// File: rtl/rxw_ptr.sv
module rxw_ptr
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic              clr,
    input  logic              adv,
    input  logic              wrap,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] cur_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we) base_q <= base_in;
            if (clr)         cur_q <= base_q;
            else if (ptr_we) cur_q <= ptr_in;
            else if (adv)    cur_q <= wrap ? base_q : cur_q + STEP;
        end
    end
endmodule

// File: rtl/rxw_len.sv
module rxw_len
    import rxw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             beat,
    input  logic             last,
    input  logic [2:0]       nbytes,
    input  logic [LEN_W-1:0] cap,
    output logic             room,
    output logic [LEN_W:0]   offset,
    output logic [LEN_W-1:0] len,
    output logic             trunc
);
    localparam int TOT_W = LEN_W + 1;
    logic [TOT_W-1:0] off_q, tot_q, cap_x, add;

    assign cap_x  = {1'b0, cap};
    assign add    = last ? TOT_W'(nbytes) : TOT_W'(4);
    assign room   = off_q < cap_x;
    assign trunc  = tot_q > cap_x;
    assign len    = trunc ? cap : tot_q[LEN_W-1:0];
    assign offset = off_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            off_q <= '0;
            tot_q <= '0;
        end else if (beat) begin
            if (room)   off_q <= off_q + TOT_W'(4);
            if (!trunc) tot_q <= tot_q + add;
        end
    end
endmodule

// File: rtl/rxw_sat.sv
module rxw_sat #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (inc && ~&cnt)      cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_en,
    input  logic              suspend,
    input  logic              clr_state,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic [2:0]        in_nbytes,
    input  logic [PORT_W-1:0] in_port,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [DROP_W-1:0] drop_count
);
    rxw_state_e        st, st_nx;
    rxw_desc_t         desc_q, desc_rd;
    logic [ADDR_W-1:0] buf_q, base_ptr, cur_ptr;
    logic [PORT_W-1:0] port_q;
    logic              room, trunc, beat, adv, drop_inc, len_start;
    logic [LEN_W:0]    offset;
    logic [LEN_W-1:0]  len;

    assign desc_rd   = decode_ctl(mem_rdata);
    assign beat      = in_valid && in_ready;
    assign len_start = (st == S_CTL);
    assign adv       = (st == S_FIN) && mem_ack;
    assign drop_inc  = (st == S_DROP) && in_valid && in_last;

    rxw_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .base_we(base_we), .base_in(base_in),
        .ptr_we(ptr_we), .ptr_in(ptr_in), .clr(clr_state),
        .adv(adv), .wrap(desc_q.eor), .base_q(base_ptr), .cur_q(cur_ptr)
    );

    rxw_len u_len (
        .clk(clk), .rst(rst), .start(len_start), .beat(beat && st == S_DATA),
        .last(in_last), .nbytes(in_nbytes), .cap(desc_q.cap),
        .room(room), .offset(offset), .len(len), .trunc(trunc)
    );

    rxw_sat #(.W(DROP_W)) u_drop (
        .clk(clk), .rst(rst), .inc(drop_inc), .cnt(drop_count)
    );

    always_comb begin
        st_nx     = st;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = '0;
        in_ready  = 1'b0;
        unique case (st)
            S_IDLE: if (in_valid && poll_en && !suspend) st_nx = S_CTL;
            S_CTL: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + ADDR_W'(OFS_CTL);
                if (mem_ack) st_nx = desc_rd.own ? S_DROP : S_ADR;
            end
            S_ADR: begin
                mem_req = 1'b1;
                if (mem_ack) st_nx = S_DATA;
            end
            S_DATA: begin
                mem_req   = in_valid && room;
                mem_we    = 1'b1;
                mem_addr  = buf_q + ADDR_W'(offset);
                mem_wdata = in_data;
                in_ready  = room ? mem_ack : 1'b1;
                if (beat && in_last) st_nx = S_STAT;
            end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + ADDR_W'(OFS_STAT);
                mem_wdata = build_stat(port_q, trunc);
                if (mem_ack) st_nx = S_FIN;
            end
            S_FIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + ADDR_W'(OFS_CTL);
                mem_wdata = build_ctl(desc_q.eor, len);
                if (mem_ack) st_nx = S_IDLE;
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            desc_q <= '0;
            buf_q  <= '0;
            port_q <= '0;
        end else begin
            st <= st_nx;
            if (st == S_CTL && mem_ack) desc_q <= desc_rd;
            if (st == S_ADR && mem_ack) buf_q  <= mem_rdata[ADDR_W-1:0];
            if (st == S_DATA && beat && in_last) port_q <= in_port;
        end
    end
endmodule

// File: rtl/rxw_chk.sv
module rxw_chk
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              poll_en,
    input logic              suspend,
    input logic              clr_state,
    input logic              ptr_we,
    input logic              in_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [DROP_W-1:0] drop_count,
    input rxw_state_e        st,
    input rxw_desc_t         desc_q,
    input logic [ADDR_W-1:0] buf_q,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic [ADDR_W-1:0] base_ptr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && (!poll_en || suspend)) |-> (!in_ready && !mem_req)); // R2

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (st == S_DROP) |-> !(mem_req && mem_we)); // R3

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + DROP_W'(1))); // R3

    AST_IN_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (st == S_DATA && mem_req) |-> ((mem_addr - buf_q) < ADDR_W'(desc_q.cap))); // R6

    AST_HANDBACK_OWN: assert property (@(posedge clk) disable iff (rst)
        (st == S_FIN && mem_req && mem_we) |-> (mem_wdata[BIT_OWN] && mem_addr == cur_ptr + ADDR_W'(OFS_CTL))); // R8

    AST_WRAP_BASE: assert property (@(posedge clk) disable iff (rst)
        (st == S_FIN && mem_ack && desc_q.eor && !clr_state && !ptr_we) |=> (cur_ptr == $past(base_ptr))); // R9

    AST_CLR_BASE: assert property (@(posedge clk) disable iff (rst)
        clr_state |=> (cur_ptr == $past(base_ptr))); // R10
endmodule

bind rx_ring_writer rxw_chk #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst(rst), .poll_en(poll_en), .suspend(suspend),
    .clr_state(clr_state), .ptr_we(ptr_we), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .drop_count(drop_count),
    .st(st), .desc_q(desc_q), .buf_q(buf_q), .cur_ptr(cur_ptr), .base_ptr(base_ptr)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        poll_en = 1'b0, suspend = 1'b0, clr_state = 1'b0;
    logic        base_we = 1'b0, ptr_we = 1'b0;
    logic [31:0] base_in = '0, ptr_in = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_nbytes = 3'd4, in_port = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  drop_count;

    logic [31:0] mem [0:255];
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;

    logic [31:0] exp_addr [0:1023];
    logic [31:0] exp_data [0:1023];
    int          exp_tag  [0:1023];
    int          wr_idx = 0;
    int          rd_idx = 0;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int cycles = 0;

    int mptr = BASE;
    int exp_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_writer dut (
        .clk(clk), .rst(rst), .poll_en(poll_en), .suspend(suspend),
        .clr_state(clr_state), .base_we(base_we), .base_in(base_in),
        .ptr_we(ptr_we), .ptr_in(ptr_in), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_nbytes(in_nbytes), .in_port(in_port), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .drop_count(drop_count)
    );

    // zero-wait memory
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (host_we) mem[host_addr[9:2]] <= host_data;
        else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // write monitor: R4 R7 R8 ordering and content
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            mon_checks++;
            if (rd_idx == wr_idx) begin
                mon_errors++;
                $display("FAIL R2 R3 unexpected write addr %h data %h, expected none", mem_addr, mem_wdata);
            end else begin
                if (mem_addr !== exp_addr[rd_idx] || mem_wdata !== exp_data[rd_idx]) begin
                    mon_errors++;
                    $display("FAIL R%0d write: got addr %h data %h, expected addr %h data %h",
                             exp_tag[rd_idx], mem_addr, mem_wdata, exp_addr[rd_idx], exp_data[rd_idx]);
                end
                rd_idx++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            $display("FAIL watchdog expired: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors",
                     checks + mon_checks + 1, errors + mon_errors + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic push(input int a, input int d, input int tag);
        exp_addr[wr_idx] = a;
        exp_data[wr_idx] = d;
        exp_tag[wr_idx]  = tag;
        wr_idx++;
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_desc(input int idx, input int bufa, input int cap, input bit eor);
        host_write(BASE + 32*idx, bufa);
        host_write(BASE + 32*idx + 4, (eor ? 32'h4000_0000 : 0) | cap);
        host_write(BASE + 32*idx + 8, 0);
    endtask

    // behavioural model + driver for one frame
    task automatic send(input int port, input int nw, input int nb, input int id);
        logic [31:0] ctl, bufa;
        int cap, total, len;
        bit trunc, eor;
        ctl = mem[(mptr + 4) >> 2];
        if (ctl[31]) begin
            exp_drop = (exp_drop < 255) ? exp_drop + 1 : 255;
        end else begin
            bufa  = mem[mptr >> 2];
            cap   = ctl[15:0];
            eor   = ctl[30];
            for (int k = 0; k < nw; k++)
                if (4*k < cap) push(bufa + 4*k, 32'hA000_0000 | (id << 8) | k, 4);
            total = (nw - 1) * 4 + nb;
            trunc = total > cap;
            len   = trunc ? cap : total;
            push(mptr + 8, (trunc << 11) | (port << 8), 7);
            push(mptr + 4, 32'hB000_0000 | (eor << 30) | len, 8);
            mptr  = eor ? BASE : mptr + 32;
        end
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = 32'hA000_0000 | (id << 8) | k;
            in_last   = (k == nw - 1);
            in_nbytes = (k == nw - 1) ? 3'(nb) : 3'd4;
            in_port   = 3'(port);
            #1;
            while (!in_ready) begin
                @(negedge clk); #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        while (rd_idx != wr_idx) @(negedge clk);
        repeat (2) @(negedge clk);
        check(rd_idx == wr_idx, "R4 R7 R8 all writes issued", rd_idx, wr_idx);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(drop_count == 0, "R1 drop_count", drop_count, 0);

        set_desc(0, 32'h200, 64, 1'b0);
        set_desc(1, 32'h240, 16, 1'b0);
        set_desc(2, 32'h280, 64, 1'b0);
        set_desc(3, 32'h2C0, 64, 1'b1);
        @(negedge clk);
        base_we = 1'b1; base_in = BASE; ptr_we = 1'b1; ptr_in = BASE;
        @(negedge clk);
        base_we = 1'b0; ptr_we = 1'b0;

        // R2: polling disabled, then suspended
        begin
            bit seen;
            seen = 1'b0;
            in_valid = 1'b1; in_data = 32'hDEAD; in_last = 1'b1; in_nbytes = 3'd4;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk); #1;
                if (in_ready || mem_req) seen = 1'b1;
            end
            check(!seen, "R2 no activity while poll_en=0", seen, 0);
            poll_en = 1'b1; suspend = 1'b1;
            seen = 1'b0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk); #1;
                if (in_ready || mem_req) seen = 1'b1;
            end
            check(!seen, "R2 no activity while suspended", seen, 0);
            suspend = 1'b0;
        end

        send(2, 5, 3, 1);   // R4 R5 R7: length 19
        send(5, 6, 4, 2);   // R6: cap 16, truncated
        send(1, 1, 1, 3);   // R5 single byte
        send(6, 3, 2, 4);   // R9: end-of-ring descriptor
        check(mem[(BASE + 32*3 + 4) >> 2][30] == 1'b1, "R8 end-of-ring kept", mem[(BASE+100)>>2], 32'h4000_0000);
        set_desc(0, 32'h200, 64, 1'b0);
        send(3, 2, 4, 5);   // R9: wrapped to base
        send(4, 2, 4, 6);   // R3: desc1 host-owned -> dropped
        check(drop_count == exp_drop, "R3 drop counted", drop_count, exp_drop);
        set_desc(1, 32'h240, 16, 1'b0);
        send(0, 2, 2, 7);   // R3: pointer did not move on drop
        set_desc(3, 32'h2C0, 64, 1'b1);
        @(negedge clk); ptr_we = 1'b1; ptr_in = BASE + 96;
        @(negedge clk); ptr_we = 1'b0; mptr = BASE + 96;
        send(7, 4, 4, 8);   // R10: loaded pointer
        set_desc(0, 32'h200, 64, 1'b0);
        mptr = BASE + 32;
        @(negedge clk); clr_state = 1'b1;
        @(negedge clk); clr_state = 1'b0; mptr = BASE;
        send(2, 2, 1, 9);   // R10: clear-state returns to base
        check(mem[(BASE + 4) >> 2][31] == 1'b1, "R8 ownership returned", mem[(BASE+4)>>2], 32'h8000_0000);

        // R3 saturation: pointer now at desc1, host-owned
        for (int n = 0; n < 256; n++) send(1, 1, 4, 10);
        check(drop_count == 8'd255, "R3 drop saturates", drop_count, 255);
        check(exp_drop == 255, "R3 model saturates", exp_drop, 255);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks, errors + mon_errors);
        $finish;
    end
endmodule